// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

The sequencer supplies the access address for a memory that is accessed in bursts of four beats. Each enabled cycle with the step control low starts a new burst: the bus address is captured as the first beat. Each enabled cycle with the step control high moves to the next beat. The next beat's address is taken from an internal two-bit beat counter, not from the bus.

Only the two low address bits are sequenced. A select input, captured when a burst starts, picks the order. In linear order the low bits count up from the start and wrap within the aligned group of four. In interleaved order the start's low bits are XORed with the beat number. The upper bits are passed through unchanged for the whole burst. A flag is high while the fourth beat's address is on the output. Stepping once more returns the output to the start address.

The output is driven from registers, so the address belonging to a control cycle appears after the next rising clock edge. When the clock enable is low, all held state is frozen.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first enabled cycle, `addr_o` is 0 and `last_o` is 0. The order is linear and the beat count is 0.
- R2: An enabled cycle with `step_i` = 0 starts a burst. After the next rising edge, `addr_o` equals the `addr_i` of that cycle and `last_o` is 0, even if the previous burst was not finished.
- R3: With the captured order linear (`order_i` = 0 at load), each enabled cycle with `step_i` = 1 makes `addr_o[1:0]` equal to (start low bits + beat number) mod 4.
- R4: With the captured order interleaved (`order_i` = 1 at load), each enabled step makes `addr_o[1:0]` equal to (start low bits XOR beat number). For example, start 1 gives 1, 0, 3, 2.
- R5: `addr_o[ADDR_W-1:2]` stays equal to the start address's upper bits for every beat. There is never a carry out of bit 1.
- R6: A step taken while the fourth beat (beat number 3) is shown wraps the output back to the start address.
- R7: `last_o` is 1 exactly while beat number 3 is shown, and 0 for beats 0 to 2.
- R8: A cycle with `en_i` = 0 leaves `addr_o` and `last_o` unchanged, whatever `step_i`, `order_i` and `addr_i` are.
- R9: `order_i` is sampled only when a burst starts. Changing it during steps has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; 0 freezes all state |
| step_i | input | 1 | 0 = load new start address, 1 = advance one beat |
| order_i | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | Start address from the bus |
| addr_o | output | ADDR_W | Current access address |
| last_o | output | 1 | High while the fourth beat is shown |

## Verification
The linear order is exercised with starts of 2, 3 and 0. The start of 3 separates a wrap inside the group from a carry into bit 2. The interleaved order is exercised with starts of 1 and 2, which separate the XOR order from the additive one.

Several other patterns are also applied:
- Disabled cycles are placed between steps, with a junk bus address and the step control high, to show that nothing moves.
- A reload in the middle of a burst confirms that the beat count restarts.
- `order_i` is toggled during an interleaved burst to confirm that the order is taken only at load.
- An asynchronous reset in the middle of a run is followed by a bare step, which checks the reset beat count and order.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEATS = 4;
  localparam int unsigned LOW_W = $clog2(BEATS);

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  typedef struct packed {
    logic load;
    logic step;
  } burst_cmd_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl (
  input  logic                 en_i,
  input  logic                 step_i,
  output burst_pkg::burst_cmd_t cmd_o
);
  always_comb begin
    cmd_o.load = en_i & ~step_i;
    cmd_o.step = en_i &  step_i;
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      order_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic [ADDR_W-1:0]         base_o,
  output burst_pkg::burst_order_e   order_o
);
  logic [ADDR_W-1:0]       base_q;
  burst_pkg::burst_order_e order_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= burst_pkg::ORD_LINEAR;
    end else if (load_i) begin
      base_q  <= addr_i;
      order_q <= burst_pkg::burst_order_e'(order_i);
    end
  end

  assign base_o  = base_q;
  assign order_o = order_q;
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] beat_o,
  output logic             last_o
);
  logic [CNT_W-1:0] beat_q;

  // natural wrap of the counter returns the burst to its start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (step_i) beat_q <= beat_q + 1'b1;
  end

  assign beat_o = beat_q;
  assign last_o = &beat_q;
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int unsigned LOW_W = 2
) (
  input  logic [LOW_W-1:0]        start_i,
  input  logic [LOW_W-1:0]        beat_i,
  input  burst_pkg::burst_order_e order_i,
  output logic [LOW_W-1:0]        low_o
);
  logic [LOW_W-1:0] lin_low;
  logic [LOW_W-1:0] xor_low;

  assign lin_low = start_i + beat_i;

  for (genvar b = 0; b < LOW_W; b++) begin : g_xor
    assign xor_low[b] = start_i[b] ^ beat_i[b];
  end

  assign low_o = (order_i == burst_pkg::ORD_XOR) ? xor_low : lin_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              step_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int unsigned LOW_W = burst_pkg::LOW_W;

  burst_pkg::burst_cmd_t   cmd;
  burst_pkg::burst_order_e order_q;
  logic [ADDR_W-1:0]       base_q;
  logic [LOW_W-1:0]        beat_q;
  logic [LOW_W-1:0]        seq_low;

  burst_ctrl u_ctrl (
    .en_i   (en_i),
    .step_i (step_i),
    .cmd_o  (cmd)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cmd.load),
    .order_i (order_i),
    .addr_i  (addr_i),
    .base_o  (base_q),
    .order_o (order_q)
  );

  burst_beat_cnt #(.CNT_W(LOW_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmd.load),
    .step_i (cmd.step),
    .beat_o (beat_q),
    .last_o (last_o)
  );

  burst_seq #(.LOW_W(LOW_W)) u_seq (
    .start_i (base_q[LOW_W-1:0]),
    .beat_i  (beat_q),
    .order_i (order_q),
    .low_o   (seq_low)
  );

  assign addr_o = {base_q[ADDR_W-1:LOW_W], seq_low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              step_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_o
);
  logic [ADDR_W-1:0] start_q;
  logic              ord_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      ord_q   <= 1'b0;
    end else if (en_i && !step_i) begin
      start_q <= addr_i;
      ord_q   <= order_i;
    end
  end

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !step_i) |=> (addr_o == $past(addr_i)) && !last_o);

  assert_lin_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && !ord_q) |=> (addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1)));

  assert_xor_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && ord_q) |=>
      ((addr_o[1:0] ^ start_q[1:0]) == 2'(($past(addr_o[1:0]) ^ start_q[1:0]) + 2'd1)));

  assert_upper_fixed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i) |=> (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])));

  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && last_o) |=> (addr_o == start_q));

  assert_last_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && last_o) |=> !last_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(addr_o) && $stable(last_o));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .step_i  (step_i),
  .order_i (order_i),
  .addr_i  (addr_i),
  .addr_o  (addr_o),
  .last_o  (last_o)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int unsigned ADDR_W = 32;
  localparam time         CLK_PERIOD = 10ns;
  localparam int          NVEC = 29;

  typedef struct packed {
    logic              en;
    logic              step;
    logic              ord;
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] exp_a;
    logic              exp_last;
    logic [3:0]        req;
  } vec_t;

  // en, step, ord, addr_i, expected addr_o, expected last_o, requirement
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b0,1'b0,32'h1000_0012,32'h1000_0012,1'b0,4'd2}, // R2 load, linear start 2
    '{1'b1,1'b1,1'b0,32'h0,        32'h1000_0013,1'b0,4'd3}, // R3
    '{1'b1,1'b1,1'b0,32'h0,        32'h1000_0010,1'b0,4'd5}, // R5 no carry
    '{1'b1,1'b1,1'b0,32'h0,        32'h1000_0011,1'b1,4'd7}, // R7 beat four
    '{1'b1,1'b1,1'b0,32'h0,        32'h1000_0012,1'b0,4'd6}, // R6 wrap
    '{1'b1,1'b0,1'b1,32'h2000_00FD,32'h2000_00FD,1'b0,4'd2}, // R2 interleaved start 1
    '{1'b1,1'b1,1'b0,32'h0,        32'h2000_00FC,1'b0,4'd4}, // R4
    '{1'b1,1'b1,1'b0,32'h0,        32'h2000_00FF,1'b0,4'd4}, // R4
    '{1'b1,1'b1,1'b0,32'h0,        32'h2000_00FE,1'b1,4'd7}, // R7
    '{1'b1,1'b1,1'b0,32'h0,        32'h2000_00FD,1'b0,4'd6}, // R6
    '{1'b0,1'b0,1'b0,32'hDEAD_BEEF,32'h2000_00FD,1'b0,4'd8}, // R8 disabled load ignored
    '{1'b1,1'b0,1'b0,32'h0000_0007,32'h0000_0007,1'b0,4'd2}, // R2 linear start 3
    '{1'b1,1'b1,1'b0,32'h0,        32'h0000_0004,1'b0,4'd5}, // R5 3 -> 0, no carry
    '{1'b1,1'b1,1'b0,32'h0,        32'h0000_0005,1'b0,4'd3}, // R3
    '{1'b0,1'b1,1'b1,32'hFFFF_FFFF,32'h0000_0005,1'b0,4'd8}, // R8 disabled step
    '{1'b1,1'b1,1'b0,32'h0,        32'h0000_0006,1'b1,4'd7}, // R7
    '{1'b0,1'b1,1'b0,32'h0,        32'h0000_0006,1'b1,4'd8}, // R8 hold last
    '{1'b1,1'b1,1'b0,32'h0,        32'h0000_0007,1'b0,4'd6}, // R6
    '{1'b1,1'b0,1'b1,32'h0000_0041,32'h0000_0041,1'b0,4'd2}, // R2 interleaved start 1
    '{1'b1,1'b1,1'b0,32'h0,        32'h0000_0040,1'b0,4'd9}, // R9 order pin now 0
    '{1'b1,1'b1,1'b0,32'h0,        32'h0000_0043,1'b0,4'd9}, // R9
    '{1'b1,1'b0,1'b0,32'h0000_0080,32'h0000_0080,1'b0,4'd2}, // R2
    '{1'b1,1'b1,1'b0,32'h0,        32'h0000_0081,1'b0,4'd3}, // R3
    '{1'b1,1'b0,1'b0,32'h0000_0092,32'h0000_0092,1'b0,4'd2}, // R2 mid-burst reload
    '{1'b1,1'b1,1'b0,32'h0,        32'h0000_0093,1'b0,4'd3}, // R3 count restarted
    '{1'b1,1'b0,1'b1,32'h0000_000A,32'h0000_000A,1'b0,4'd2}, // R2 interleaved start 2
    '{1'b1,1'b1,1'b1,32'h0,        32'h0000_000B,1'b0,4'd4}, // R4
    '{1'b1,1'b1,1'b1,32'h0,        32'h0000_0008,1'b0,4'd4}, // R4
    '{1'b1,1'b1,1'b1,32'h0,        32'h0000_0009,1'b1,4'd4}  // R4 with last
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic              step_i = 1'b0;
  logic              order_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic              last_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(ADDR_W)) dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .step_i  (step_i),
    .order_i (order_i),
    .addr_i  (addr_i),
    .addr_o  (addr_o),
    .last_o  (last_o)
  );

  task automatic check(input string req, input logic [ADDR_W-1:0] ea, input logic el);
    n_chk++;
    if (addr_o !== ea || last_o !== el) begin
      n_err++;
      $display("FAIL %s: addr_o=%h last_o=%b expected addr_o=%h last_o=%b",
               req, addr_o, last_o, ea, el);
    end
  endtask

  task automatic apply(input logic en, input logic st, input logic od, input logic [ADDR_W-1:0] a);
    en_i = en; step_i = st; order_i = od; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1", '0, 1'b0);               // R1 held in reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", '0, 1'b0);               // R1 idle after release

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].en, VECS[i].step, VECS[i].ord, VECS[i].a);
      check($sformatf("R%0d", VECS[i].req), VECS[i].exp_a, VECS[i].exp_last);
    end

    // R1: async reset mid-burst, then bare steps from reset state
    apply(1'b1, 1'b0, 1'b1, 32'h5555_5556);
    apply(1'b1, 1'b1, 1'b1, 32'h0);
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    check("R1", '0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(1'b1, 1'b1, 1'b1, 32'h0);
    check("R1", 32'h1, 1'b0);            // linear from 0, order pin ignored
    apply(1'b1, 1'b1, 1'b1, 32'h0);
    apply(1'b1, 1'b1, 1'b1, 32'h0);
    check("R1", 32'h3, 1'b1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule